// File: doc/BRIEF.md
# Clocked Programmable Delay Line

This block delays a single-bit signal by a whole number of clock cycles. A 6-bit code picks one of 64 settings. The delay in cycles is a fixed base plus the code times a per-step increment, and both values are parameters. The code is not captured inside the block. It selects a tap of an internal shift register live, on every cycle, so the caller must hold it steady while an edge is travelling down the line. An active-high disable input forces the output low.

Guard logic checks how the line is being used. `addr_safe` reports whether the code now on the input may replace the code from the previous cycle. A raise from the old code to the new code needs the output to have been quiet for (new − old)·step cycles. A lowering, or no change, is always safe. `clear_done` reports whether a disable has been held long enough to empty the line. `violation` pulses after any misuse: an unsafe code change, a disable released too early, or an input pulse that is too short for the programmed delay.

The clearing guard is a three-state machine. RUN is the normal operating state. DRAIN means the disable is held but the line is not yet empty. HELD means the disable is held and the line is empty. The transitions are: RUN→DRAIN when disable is seen and the count of quiet disabled cycles is still short of the need; RUN→HELD when disable is seen and that count already meets the need; DRAIN→HELD when the count reaches the need; DRAIN→RUN on early release, which flags a violation; HELD→DRAIN when the input goes high while disabled; HELD→RUN on release.

Top module: `prog_delay_line`

## Requirements
- R1: With `dis` low, the value of `din` sampled at rising edge k appears on `dout` after edge k+D, where D = BASE + addr·STEP and addr is the unsigned binary value of `addr`. D grows strictly with the code.
- R2: The code is not latched. After any edge k, `dout` shows the `din` sample from edge k−D, with D taken from the code sampled at edge k, even when the code changed at that edge.
- R3: When `dis` (active high) is sampled high at an edge, `dout` is low after that edge. Once `dis` is low again, `dout` follows the line as in R2.
- R4: `addr_safe` depends on the present `addr` in the same cycle. It is high exactly when the number of edges since the last edge at which `dout` changed is at least max((addr − ref)·STEP, 0), where ref is the code sampled at the previous edge. The count saturates at 63·STEP. An unchanged or lower code is always safe.
- R5: Let n = max(addr·STEP, 1). `clear_done` is low only in DRAIN. While `dis` is high, it rises after the edge that completes n consecutive edges with `dis` high and `din` low. A high `din` while disabled restarts that count and moves the state to DRAIN. Once HELD, the state stays there while `din` stays low.
- R6: `violation` is high in the cycle after an edge at which `addr` differed from the previous sample while `addr_safe` was low.
- R7: `violation` is high in the cycle after an edge at which `dis` was sampled low while `clear_done` was low.
- R8: `violation` is high in the cycle after an edge at which `din` is sampled low after a run of W consecutive high samples with 5·W < D. This is a high pulse shorter than 20% of the programmed delay.
- R9: During reset (`rst_n` low), `dout` and `violation` are low and `addr_safe` and `clear_done` are high. The line is emptied, so a `din` that was high during reset never reaches `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Signal to be delayed |
| addr | input | 6 | Delay code, unsigned, read live |
| dis | input | 1 | Output disable, active high |
| dout | output | 1 | Delayed signal, registered |
| addr_safe | output | 1 | Present code may replace the previous one |
| clear_done | output | 1 | Disable has emptied the line |
| violation | output | 1 | One-cycle misuse flag, registered |

## Verification
`dout` is due D edges after the `din` sample it carries, using the code present at the edge of arrival. `clear_done` and `violation` change after the edge that samples their cause. `addr_safe` is combinational in `addr`, so it is checked one time step after a new code is applied and before the next rising edge. The bench applies every input on the falling edge. It advances its own arithmetic model at the rising edge and compares the registered outputs at the following falling edge, so each result is read in the exact cycle the requirement names. The sweeps cover all 64 codes going up and going down, disables held one cycle short of and past the clearing need, and pulse widths on each side of the 20% limit.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Clearing guard states
    typedef enum logic [1:0] {
        CLR_RUN   = 2'd0,   // normal operation
        CLR_DRAIN = 2'd1,   // disabled, line not yet empty
        CLR_HELD  = 2'd2    // disabled, line empty
    } clr_state_e;

    // Ratio used for the short pulse rule: width * PW_RATIO < delay
    localparam int unsigned PW_RATIO = 5;

endpackage

// File: rtl/pdl_tap_line.sv
module pdl_tap_line #(
    parameter int unsigned BASE   = 2,
    parameter int unsigned STEP   = 1,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dis,
    output logic              dout,
    output logic              dout_edge
);
    localparam int unsigned N_TAPS = 1 << ADDR_W;
    localparam int unsigned DEPTH  = BASE + (N_TAPS - 1) * STEP;

    logic [DEPTH-1:0]  line_q;
    logic [N_TAPS-1:0] taps;
    logic              dout_nxt;

    // Shift register: bit 0 holds the newest sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[DEPTH-2:0], din};
        end
    end

    // One tap per code; code c gives a total delay of BASE + c*STEP edges
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign taps[g] = line_q[BASE - 1 + g * STEP];
    end

    assign dout_nxt  = dis ? 1'b0 : taps[addr];
    assign dout_edge = dout_nxt ^ dout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else begin
            dout <= dout_nxt;
        end
    end

    // R3: a sampled disable leaves the output low after the edge
    a_r3_disable_forces_low: assert property (
        @(posedge clk) disable iff (!rst_n) dis |=> !dout
    );

endmodule

// File: rtl/pdl_addr_guard.sv
module pdl_addr_guard #(
    parameter int unsigned STEP   = 1,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dout_edge,
    output logic              addr_safe,
    output logic              addr_evt
);
    localparam int unsigned MAXW = ((1 << ADDR_W) - 1) * STEP;
    localparam int unsigned QW   = $clog2(MAXW + 1);

    logic [ADDR_W-1:0] addr_ref_q;
    logic [ADDR_W-1:0] diff;
    logic [QW-1:0]     quiet_q;
    logic [QW-1:0]     need;

    assign diff      = addr - addr_ref_q;
    assign need      = (addr > addr_ref_q) ? QW'(32'(diff) * STEP) : '0;
    assign addr_safe = (quiet_q >= need);
    assign addr_evt  = (addr != addr_ref_q) && !addr_safe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_ref_q <= '0;
            quiet_q    <= QW'(MAXW);
        end else begin
            addr_ref_q <= addr;
            if (dout_edge) begin
                quiet_q <= '0;
            end else if (quiet_q != QW'(MAXW)) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    // R4: right after an output change only a raise of the code is unsafe
    a_r4_edge_blocks_raise: assert property (
        @(posedge clk) disable iff (!rst_n)
        dout_edge |=> (addr_safe == (addr <= addr_ref_q))
    );

endmodule

// File: rtl/pdl_clear_fsm.sv
module pdl_clear_fsm
    import pdl_pkg::*;
#(
    parameter int unsigned STEP   = 1,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              dis,
    input  logic [ADDR_W-1:0] addr,
    output logic              clear_done,
    output logic              early_evt
);
    localparam int unsigned MAXW = ((1 << ADDR_W) - 1) * STEP;
    localparam int unsigned CW   = $clog2(MAXW + 1);

    clr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc, need;

    assign need    = (addr == '0) ? CW'(1) : CW'(32'(addr) * STEP);
    assign cnt_inc = (cnt_q == CW'(MAXW)) ? cnt_q : cnt_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CLR_RUN: begin
                if (dis) begin
                    cnt_d   = din ? '0 : CW'(1);
                    state_d = (cnt_d >= need) ? CLR_HELD : CLR_DRAIN;
                end else begin
                    cnt_d = '0;
                end
            end
            CLR_DRAIN: begin
                if (!dis) begin
                    state_d = CLR_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = din ? '0 : cnt_inc;
                    state_d = (cnt_d >= need) ? CLR_HELD : CLR_DRAIN;
                end
            end
            CLR_HELD: begin
                if (!dis) begin
                    state_d = CLR_RUN;
                    cnt_d   = '0;
                end else if (din) begin
                    state_d = CLR_DRAIN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = CLR_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        clear_done = (state_q != CLR_DRAIN);
        early_evt  = (state_q == CLR_DRAIN) && !dis;
    end

    // R5: clear_done can only drop after a sampled disable
    a_r5_drop_needs_disable: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(clear_done) |-> $past(dis)
    );

    // R5: an emptied line stays clear while the input stays low
    a_r5_held_is_sticky: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == CLR_HELD && dis && !din) |=> clear_done
    );

endmodule

// File: rtl/pdl_pulse_check.sv
module pdl_pulse_check
    import pdl_pkg::*;
#(
    parameter int unsigned BASE   = 2,
    parameter int unsigned STEP   = 1,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    output logic              short_evt
);
    localparam int unsigned DEPTH = BASE + ((1 << ADDR_W) - 1) * STEP;
    localparam int unsigned HW    = $clog2(DEPTH + 1);

    logic          din_q;
    logic [HW-1:0] hcnt_q;
    logic [31:0]   span;
    logic [31:0]   width_scaled;

    assign span         = BASE + 32'(addr) * STEP;
    assign width_scaled = 32'(hcnt_q) * PW_RATIO;
    assign short_evt    = din_q && !din && (width_scaled < span);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q  <= 1'b0;
            hcnt_q <= '0;
        end else begin
            din_q <= din;
            if (!din) begin
                hcnt_q <= '0;
            end else if (hcnt_q != HW'(DEPTH)) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
    parameter int unsigned BASE   = 2,
    parameter int unsigned STEP   = 1,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dis,
    output logic              dout,
    output logic              addr_safe,
    output logic              clear_done,
    output logic              violation
);
    logic dout_edge;
    logic addr_evt;
    logic early_evt;
    logic short_evt;

    pdl_tap_line #(.BASE(BASE), .STEP(STEP), .ADDR_W(ADDR_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .addr      (addr),
        .dis       (dis),
        .dout      (dout),
        .dout_edge (dout_edge)
    );

    pdl_addr_guard #(.STEP(STEP), .ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .dout_edge (dout_edge),
        .addr_safe (addr_safe),
        .addr_evt  (addr_evt)
    );

    pdl_clear_fsm #(.STEP(STEP), .ADDR_W(ADDR_W)) u_clear (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .dis        (dis),
        .addr       (addr),
        .clear_done (clear_done),
        .early_evt  (early_evt)
    );

    pdl_pulse_check #(.BASE(BASE), .STEP(STEP), .ADDR_W(ADDR_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .addr      (addr),
        .short_evt (short_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            violation <= 1'b0;
        end else begin
            violation <= addr_evt | early_evt | short_evt;
        end
    end

    // R6: a sampled unsafe code always raises the flag
    a_r6_unsafe_code_flagged: assert property (
        @(posedge clk) disable iff (!rst_n) !addr_safe |=> violation
    );

    // R7: releasing the disable before the line is clear raises the flag
    a_r7_early_release_flagged: assert property (
        @(posedge clk) disable iff (!rst_n) (!clear_done && !dis) |=> violation
    );

endmodule

// File: tb/prog_delay_line_test.sv
module prog_delay_line_test;
    localparam int BASE = 2;
    localparam int STEP = 1;
    localparam int AW   = 6;
    localparam int NT   = 1 << AW;
    localparam int MAXW = (NT - 1) * STEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic dis = 1'b0;
    logic [AW-1:0] addr = '0;
    logic dout, addr_safe, clear_done, violation;

    always #4 clk = ~clk;

    prog_delay_line #(.BASE(BASE), .STEP(STEP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .dis(dis),
        .dout(dout), .addr_safe(addr_safe), .clear_done(clear_done),
        .violation(violation)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Model state
    bit hist [256];
    int k        = 0;
    int lastchg  = -100000;
    int a_prev   = 0;
    bit cd_prev  = 1;
    bit dis_prev = 0;
    bit din_prev = 0;
    bit dout_prev = 0;
    int run = 0;
    int hw  = 0;
    bit [15:0] lfsr = 16'hACE1;

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: got=%0b exp=%0b", tag, what, k, got, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Apply inputs at the falling edge, model the rising edge, check at the next falling edge
    task automatic cycle(input bit ndin, input bit ndis, input int naddr);
        int quiet, wt, d, need;
        bit safe, ed, ev_a, ev_e, ev_s, cd;
        string tg;
        din  = ndin;
        dis  = ndis;
        addr = naddr[AW-1:0];
        #1;
        quiet = k - lastchg;
        if (quiet > MAXW) quiet = MAXW;
        wt   = (naddr > a_prev) ? (naddr - a_prev) * STEP : 0;
        safe = (quiet >= wt);
        check("R4", "addr_safe", addr_safe, safe);
        @(posedge clk);
        k++;
        hist[k % 256] = ndin;
        d  = BASE + naddr * STEP;
        ed = ndis ? 1'b0 : ((k - d >= 1) ? hist[(k - d) % 256] : 1'b0);
        if (ed != dout_prev) lastchg = k;
        ev_a = (naddr != a_prev) && !safe;
        need = naddr * STEP;
        if (need < 1) need = 1;
        if (ndis) begin
            run = ndin ? 0 : (dis_prev ? run + 1 : 1);
            cd  = ndin ? 1'b0 : ((dis_prev && cd_prev) || (run >= need));
        end else begin
            run = 0;
            cd  = 1'b1;
        end
        ev_e = !ndis && !cd_prev;
        ev_s = din_prev && !ndin && (5 * hw < d);
        hw   = ndin ? hw + 1 : 0;
        @(negedge clk);
        if (ndis) tg = "R3";
        else if (naddr != a_prev) tg = "R2";
        else tg = "R1";
        check(tg, "dout", dout, ed);
        check("R5", "clear_done", clear_done, cd);
        if (ev_s) tg = "R8";
        else if (ev_e) tg = "R7";
        else tg = "R6";
        check(tg, "violation", violation, ev_a | ev_e | ev_s);
        a_prev    = naddr;
        cd_prev   = cd;
        dis_prev  = ndis;
        din_prev  = ndin;
        dout_prev = ed;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: got=timeout exp=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int dis_codes [5] = '{0, 1, 5, 20, 63};
        int widths [6]    = '{1, 2, 12, 13, 14, 30};
        int pw_codes [3]  = '{63, 0, 10};

        // R9: reset values, with din high so the line would fill if not cleared
        din = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "dout", dout, 1'b0);
        check("R9", "addr_safe", addr_safe, 1'b1);
        check("R9", "clear_done", clear_done, 1'b1);
        check("R9", "violation", violation, 1'b0);
        din = 1'b0;
        rst_n = 1'b1;

        // R1/R2: ascending sweep over every code
        for (int a = 0; a < NT; a++) begin
            repeat (6) cycle(1'b0, 1'b0, a);
            for (int i = 0; i < BASE + a * STEP + 6; i++) begin
                next_rand();
                cycle(lfsr[0], 1'b0, a);
            end
        end

        // R1/R2/R4: descending sweep with sparser pulses
        for (int a = NT - 1; a >= 0; a--) begin
            for (int i = 0; i < 10; i++) begin
                next_rand();
                cycle(lfsr[0] & lfsr[3], 1'b0, a);
            end
        end
        repeat (80) cycle(1'b0, 1'b0, 0);

        // R3/R5/R7: disable held one short of the need and past it
        foreach (dis_codes[j]) begin
            for (int ex = -1; ex <= 2; ex += 3) begin
                int nd;
                nd = dis_codes[j] * STEP;
                if (nd < 1) nd = 1;
                nd = nd + ex;
                for (int i = 0; i < 10; i++) begin
                    next_rand();
                    cycle(lfsr[0], 1'b0, dis_codes[j]);
                end
                for (int i = 0; i < nd; i++) cycle(1'b0, 1'b1, dis_codes[j]);
                repeat (5) cycle(1'b0, 1'b0, dis_codes[j]);
                repeat (BASE + dis_codes[j] * STEP + 2) cycle(1'b0, 1'b0, dis_codes[j]);
            end
        end

        // R5: input goes high while disabled, count restarts
        repeat (10) cycle(1'b0, 1'b1, 20);
        cycle(1'b1, 1'b1, 20);
        repeat (25) cycle(1'b0, 1'b1, 20);
        cycle(1'b1, 1'b1, 20);
        repeat (3) cycle(1'b0, 1'b0, 20);
        repeat (30) cycle(1'b0, 1'b0, 20);

        // R8: pulse widths either side of the 20% limit
        foreach (pw_codes[j]) begin
            foreach (widths[m]) begin
                repeat (widths[m]) cycle(1'b1, 1'b0, pw_codes[j]);
                repeat (BASE + pw_codes[j] * STEP + 5) cycle(1'b0, 1'b0, pw_codes[j]);
            end
        end

        // R4/R6: raise the code at varying quiet times after an output edge
        for (int m = 0; m < 14; m++) begin
            repeat (3) cycle(1'b1, 1'b0, 10);
            repeat (12 + m) cycle(1'b0, 1'b0, 10);
            cycle(1'b0, 1'b0, 20);
            repeat (30) cycle(1'b0, 1'b0, 20);
            cycle(1'b0, 1'b0, 10);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule